// File: doc/BRIEF.md
# Context Memory Maintenance-Slot Arbiter

This block owns the path to an external connection-context memory that two agents share: a cell-processing engine and a host processor. In normal running the engine alone reaches the memory. For every cell it reads the connection's entry and then writes back the updated dynamic words. Host requests are not served in that state. They wait for a maintenance slot, which the block opens after a host-programmed number of running cycles. During a slot, cell intake stops, the engine is told to stall, and the memory bus is handed to the host. The slot ends after a programmed length or when the host reports that it is done. The engine then gets the bus back.

The block never splits an engine read-modify-write. When the interval expires, the block first closes cell intake. It then waits for the engine's busy flag to fall and only after that grants the slot. Cells offered upstream during the wait or the slot are held by deasserting ready, so none is lost.

The block also protects the static half of each context entry from engine writes. It drives one select line per memory bank, decoded from the top of the 24-bit byte address.

Top module: `ctxmem_slot_arbiter`

## Requirements
- R1: While `host_gnt_o` is low, host request inputs have no effect on the memory port. `mem_en_o` follows `eng_req_i`, and `mem_addr_o`/`mem_wdata_o` carry the engine's values.
- R2: With a non-zero interval I, the low gap between the end of one slot and the start of the next lasts I+1 clock cycles when the engine is never busy. This is I counted running cycles plus one hand-off cycle.
- R3: A slot lasts `cfg_slot_len_i` cycles, or one cycle when that value is 0, unless it is ended early.
- R4: A `host_done_i` sampled high during a slot ends the slot: `host_gnt_o` is low from the next cycle on.
- R5: After the interval expires, the grant is withheld while `eng_busy_i` is high. It rises on the clock edge after the first cycle in which `eng_busy_i` is sampled low.
- R6: `cell_ready_o` equals `eng_ready_i` only while running. It is low from interval expiry until the slot ends. `eng_cell_valid_o` is `cell_valid_i` AND `cell_ready_o`.
- R7: While `host_gnt_o` is high, `eng_stall_o` is high and the memory port follows the host inputs: enable from `host_req_i`, write from `host_req_i` AND `host_we_i`. Engine request inputs have no effect.
- R8: Each entry has 8 words. The word index is `addr[4:2]`, and indices 0 to 3 form the static region. An engine write to a static word gives `mem_we_o` low. Host writes reach every word.
- R9: `mem_bank_o[k]` is high exactly when `mem_en_o` is high and `mem_addr_o[23:22]` equals k. All four lines are low when `mem_en_o` is low.
- R10: An interval value of 0 never opens a slot.
- R11: Host data is 32 bits and reaches `mem_wdata_o` unchanged during a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_interval_i | input | IVL_W | Running cycles between slots, 0 disables slots |
| cfg_slot_len_i | input | SLOT_W | Slot length in cycles |
| cell_valid_i | input | 1 | Upstream cell offered |
| cell_ready_o | output | 1 | Upstream cell may be taken |
| eng_cell_valid_o | output | 1 | Cell handed to the engine this cycle |
| eng_ready_i | input | 1 | Engine can accept a cell |
| eng_busy_i | input | 1 | Engine read-modify-write in progress |
| eng_stall_o | output | 1 | Engine must hold, slot active |
| eng_req_i | input | 1 | Engine memory access |
| eng_we_i | input | 1 | Engine access is a write |
| eng_addr_i | input | ADDR_W | Engine byte address |
| eng_wdata_i | input | DATA_W | Engine write data |
| host_req_i | input | 1 | Host memory access |
| host_we_i | input | 1 | Host access is a write |
| host_addr_i | input | ADDR_W | Host byte address |
| host_wdata_i | input | DATA_W | Host write data |
| host_done_i | input | 1 | Host ends the slot early |
| host_gnt_o | output | 1 | Slot active, host owns the bus |
| mem_en_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_bank_o | output | BANKS | One-hot bank select |

## Verification
The bench builds the block with a 6-bit interval and a 4-bit slot length. This makes a full sweep of intervals 1 to 10 against slot lengths 0 to 5 cheap. Each configuration's gap and slot widths are measured against I+1 and max(L,1). With the address width, bank count and entry layout kept at their defaults, every bank, word index, write flag and requester combination can be driven in both the running and the slot state. The deferral, early-end and disabled-interval cases are run as directed sequences.

// File: rtl/ctxarb_pkg.sv
package ctxarb_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_SLOT = 2'd2
  } arb_state_e;
endpackage

// File: rtl/ctxarb_interval_timer.sv
module ctxarb_interval_timer #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [IVL_W-1:0] interval_i,
  output logic             tick_o
);
  logic [IVL_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             enabled;

  always_comb begin
    enabled = (interval_i != '0);
    tick_o  = run_i && enabled && (cnt_q >= (interval_i - IVL_W'(1)));
    cnt_en  = run_i || (cnt_q != '0);
    if (!run_i || !enabled || tick_o) cnt_d = '0;
    else                              cnt_d = cnt_q + IVL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ctxarb_slot_ctrl.sv
module ctxarb_slot_ctrl
  import ctxarb_pkg::*;
#(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              eng_busy_i,
  input  logic              host_done_i,
  input  logic [SLOT_W-1:0] slot_len_i,
  output logic              run_o,
  output logic              slot_o
);
  localparam int SW1 = SLOT_W + 1;

  arb_state_e        state_q, state_d;
  logic [SLOT_W-1:0] scnt_q, scnt_d;
  logic              scnt_en;
  logic              last_cyc;

  always_comb begin
    last_cyc = (({1'b0, scnt_q} + SW1'(1)) >= {1'b0, slot_len_i});
    state_d  = state_q;
    scnt_d   = scnt_q;
    scnt_en  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (tick_i) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (!eng_busy_i) begin
          state_d = ST_SLOT;
          scnt_en = 1'b1;
          scnt_d  = '0;
        end
      end
      ST_SLOT: begin
        scnt_en = 1'b1;
        if (host_done_i || last_cyc) begin
          state_d = ST_RUN;
          scnt_d  = '0;
        end else begin
          scnt_d  = scnt_q + SLOT_W'(1);
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       scnt_q <= '0;
    else if (scnt_en) scnt_q <= scnt_d;
  end

  assign run_o  = (state_q == ST_RUN);
  assign slot_o = (state_q == ST_SLOT);
endmodule

// File: rtl/ctxarb_bus_mux.sv
module ctxarb_bus_mux #(
  parameter int ADDR_W       = 24,
  parameter int DATA_W       = 32,
  parameter int BANKS        = 4,
  parameter int ENTRY_LG2    = 3,
  parameter int STATIC_WORDS = 4
) (
  input  logic              sel_host_i,
  input  logic              eng_req_i,
  input  logic              eng_we_i,
  input  logic [ADDR_W-1:0] eng_addr_i,
  input  logic [DATA_W-1:0] eng_wdata_i,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [BANKS-1:0]  mem_bank_o
);
  localparam int BSEL_W = $clog2(BANKS);
  localparam int WIDX_W = ENTRY_LG2 + 1;
  localparam logic [WIDX_W-1:0] STATIC_LIM = WIDX_W'(STATIC_WORDS);

  logic [ENTRY_LG2-1:0] eng_word;
  logic                 eng_static;
  logic [BSEL_W-1:0]    bank_idx;

  always_comb begin
    eng_word   = eng_addr_i[ENTRY_LG2+1:2];
    eng_static = ({1'b0, eng_word} < STATIC_LIM);
    if (sel_host_i) begin
      mem_en_o    = host_req_i;
      mem_we_o    = host_req_i && host_we_i;
      mem_addr_o  = host_addr_i;
      mem_wdata_o = host_wdata_i;
    end else begin
      mem_en_o    = eng_req_i;
      mem_we_o    = eng_req_i && eng_we_i && !eng_static;
      mem_addr_o  = eng_addr_i;
      mem_wdata_o = eng_wdata_i;
    end
    bank_idx = mem_addr_o[ADDR_W-1 -: BSEL_W];
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign mem_bank_o[b] = mem_en_o && (bank_idx == BSEL_W'(b));
  end
endmodule

// File: rtl/ctxmem_slot_arbiter.sv
module ctxmem_slot_arbiter #(
  parameter int IVL_W        = 16,
  parameter int SLOT_W       = 8,
  parameter int ADDR_W       = 24,
  parameter int DATA_W       = 32,
  parameter int BANKS        = 4,
  parameter int ENTRY_LG2    = 3,
  parameter int STATIC_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IVL_W-1:0]  cfg_interval_i,
  input  logic [SLOT_W-1:0] cfg_slot_len_i,
  input  logic              cell_valid_i,
  output logic              cell_ready_o,
  output logic              eng_cell_valid_o,
  input  logic              eng_ready_i,
  input  logic              eng_busy_i,
  output logic              eng_stall_o,
  input  logic              eng_req_i,
  input  logic              eng_we_i,
  input  logic [ADDR_W-1:0] eng_addr_i,
  input  logic [DATA_W-1:0] eng_wdata_i,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              host_done_i,
  output logic              host_gnt_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [BANKS-1:0]  mem_bank_o
);
  logic running;
  logic in_slot;
  logic tick;

  ctxarb_interval_timer #(.IVL_W(IVL_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (running),
    .interval_i (cfg_interval_i),
    .tick_o     (tick)
  );

  ctxarb_slot_ctrl #(.SLOT_W(SLOT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .eng_busy_i  (eng_busy_i),
    .host_done_i (host_done_i),
    .slot_len_i  (cfg_slot_len_i),
    .run_o       (running),
    .slot_o      (in_slot)
  );

  ctxarb_bus_mux #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .BANKS        (BANKS),
    .ENTRY_LG2    (ENTRY_LG2),
    .STATIC_WORDS (STATIC_WORDS)
  ) u_mux (
    .sel_host_i   (in_slot),
    .eng_req_i    (eng_req_i),
    .eng_we_i     (eng_we_i),
    .eng_addr_i   (eng_addr_i),
    .eng_wdata_i  (eng_wdata_i),
    .host_req_i   (host_req_i),
    .host_we_i    (host_we_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .mem_en_o     (mem_en_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_bank_o   (mem_bank_o)
  );

  assign cell_ready_o     = eng_ready_i && running;
  assign eng_cell_valid_o = cell_valid_i && cell_ready_o;
  assign eng_stall_o      = in_slot;
  assign host_gnt_o       = in_slot;
endmodule

// File: rtl/ctxarb_checker.sv
module ctxarb_checker #(
  parameter int IVL_W        = 16,
  parameter int SLOT_W       = 8,
  parameter int BANKS        = 4,
  parameter int ENTRY_LG2    = 3,
  parameter int STATIC_WORDS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [IVL_W-1:0]     cfg_interval,
  input logic [SLOT_W-1:0]    cfg_slot_len,
  input logic                 eng_busy,
  input logic                 cell_ready,
  input logic                 eng_req,
  input logic                 host_req,
  input logic                 host_done,
  input logic                 host_gnt,
  input logic                 mem_en,
  input logic                 mem_we,
  input logic [ENTRY_LG2-1:0] mem_word,
  input logic [BANKS-1:0]     mem_bank
);
  localparam int SW1 = SLOT_W + 1;
  localparam int WIDX_W = ENTRY_LG2 + 1;
  localparam logic [WIDX_W-1:0] STATIC_LIM = WIDX_W'(STATIC_WORDS);

  logic [SW1-1:0] gcnt_q;
  logic [SW1-1:0] glim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    gcnt_q <= '0;
    else if (!host_gnt)            gcnt_q <= '0;
    else if (gcnt_q != {SW1{1'b1}}) gcnt_q <= gcnt_q + SW1'(1);
  end

  assign glim = (cfg_slot_len == '0) ? SW1'(1) : {1'b0, cfg_slot_len};

  assert_host_locked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_gnt && host_req && !eng_req) |-> !mem_en);

  assert_slot_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    host_gnt |-> (gcnt_q < glim));

  assert_done_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_gnt && host_done) |=> !host_gnt);

  assert_no_split_rmw_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_gnt) |-> $past(!eng_busy));

  assert_backpressure_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_gnt |-> !cell_ready);

  assert_host_owns_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_gnt && !host_req && eng_req) |-> !mem_en);

  assert_static_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_gnt && mem_we) |-> ({1'b0, mem_word} >= STATIC_LIM));

  assert_bank_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> ($countones(mem_bank) == 1));

  assert_bank_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en |-> (mem_bank == '0));

  assert_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_interval == '0) && !host_gnt && cell_ready) |=> !host_gnt);
endmodule

bind ctxmem_slot_arbiter ctxarb_checker #(
  .IVL_W        (IVL_W),
  .SLOT_W       (SLOT_W),
  .BANKS        (BANKS),
  .ENTRY_LG2    (ENTRY_LG2),
  .STATIC_WORDS (STATIC_WORDS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_interval (cfg_interval_i),
  .cfg_slot_len (cfg_slot_len_i),
  .eng_busy     (eng_busy_i),
  .cell_ready   (cell_ready_o),
  .eng_req      (eng_req_i),
  .host_req     (host_req_i),
  .host_done    (host_done_i),
  .host_gnt     (host_gnt_o),
  .mem_en       (mem_en_o),
  .mem_we       (mem_we_o),
  .mem_word     (mem_addr_o[ENTRY_LG2+1:2]),
  .mem_bank     (mem_bank_o)
);

// File: tb/ctxmem_slot_arbiter_tb_top.sv
`timescale 1ns/1ps
module ctxmem_slot_arbiter_tb_top;
  localparam int IVL_W  = 6;
  localparam int SLOT_W = 4;

  logic              clk;
  logic              rst_n;
  logic [IVL_W-1:0]  cfg_interval;
  logic [SLOT_W-1:0] cfg_slot_len;
  logic              cell_valid, cell_ready, eng_cell_valid;
  logic              eng_ready, eng_busy, eng_stall;
  logic              eng_req, eng_we;
  logic [23:0]       eng_addr;
  logic [31:0]       eng_wdata;
  logic              host_req, host_we, host_done, host_gnt;
  logic [23:0]       host_addr;
  logic [31:0]       host_wdata;
  logic              mem_en, mem_we;
  logic [23:0]       mem_addr;
  logic [31:0]       mem_wdata;
  logic [3:0]        mem_bank;

  int checks = 0;
  int errors = 0;

  ctxmem_slot_arbiter #(.IVL_W(IVL_W), .SLOT_W(SLOT_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_interval_i(cfg_interval), .cfg_slot_len_i(cfg_slot_len),
    .cell_valid_i(cell_valid), .cell_ready_o(cell_ready),
    .eng_cell_valid_o(eng_cell_valid),
    .eng_ready_i(eng_ready), .eng_busy_i(eng_busy), .eng_stall_o(eng_stall),
    .eng_req_i(eng_req), .eng_we_i(eng_we), .eng_addr_i(eng_addr),
    .eng_wdata_i(eng_wdata),
    .host_req_i(host_req), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_done_i(host_done), .host_gnt_o(host_gnt),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_bank_o(mem_bank)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int ivl, input int slen);
    rst_n = 1'b0;
    cfg_interval = IVL_W'(ivl);
    cfg_slot_len = SLOT_W'(slen);
    cell_valid = 1'b1; eng_ready = 1'b1; eng_busy = 1'b0;
    eng_req = 1'b0; eng_we = 1'b0; eng_addr = '0; eng_wdata = '0;
    host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    host_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic measure(output int n, input logic lvl);
    n = 0;
    while (host_gnt == lvl && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int g0, s1, gap, s2;

    // Reset state
    do_reset(0, 1);
    chk(host_gnt == 1'b0, "R7 gnt after reset", host_gnt, 0);
    chk(eng_stall == 1'b0, "R7 stall after reset", eng_stall, 0);
    chk(cell_ready == 1'b1, "R6 ready after reset", cell_ready, 1);

    // Running: exhaustive engine/host patterns with slots disabled
    host_req = 1'b1; host_we = 1'b1; host_wdata = 32'hDEAD_BEEF;
    host_addr = 24'hC0_0000;
    for (int b = 0; b < 4; b++) begin
      for (int w = 0; w < 8; w++) begin
        for (int we = 0; we < 2; we++) begin
          for (int er = 0; er < 2; er++) begin
            logic [3:0] bexp;
            logic       wexp;
            @(negedge clk);
            eng_req   = er[0];
            eng_we    = we[0];
            eng_addr  = {2'(b), 17'(b * 777 + w * 13), 3'(w), 2'b00};
            eng_wdata = 32'h1000_0000 + 32'(b * 64 + w * 8 + we * 2 + er);
            #1;
            bexp = er[0] ? (4'b0001 << b) : 4'b0000;
            wexp = er[0] && we[0] && (w >= 4);
            chk(mem_en == er[0], "R1 mem_en follows engine", mem_en, er);
            chk(mem_addr == eng_addr && mem_wdata == eng_wdata,
                "R1 engine path", mem_addr, eng_addr);
            chk(mem_we == wexp, "R8 static write guard", mem_we, wexp);
            chk(mem_bank == bexp, "R9 bank select", mem_bank, bexp);
          end
        end
      end
    end
    chk(eng_cell_valid == 1'b1, "R6 cell accepted while running", eng_cell_valid, 1);

    // R10: interval 0 keeps slots off
    begin
      int seen = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (host_gnt) seen++;
      end
      chk(seen == 0, "R10 no slot with interval 0", seen, 0);
    end

    // R2/R3 sweep of interval and slot length
    for (int iv = 1; iv <= 10; iv++) begin
      for (int sl = 0; sl <= 5; sl++) begin
        int exp_len;
        exp_len = (sl == 0) ? 1 : sl;
        do_reset(iv, sl);
        measure(g0, 1'b0);
        chk(eng_stall == 1'b1 && cell_ready == 1'b0, "R6 held during slot",
            cell_ready, 0);
        measure(s1, 1'b1);
        measure(gap, 1'b0);
        measure(s2, 1'b1);
        chk(s1 == exp_len, "R3 first slot length", s1, exp_len);
        chk(s2 == exp_len, "R3 second slot length", s2, exp_len);
        chk(gap == iv + 1, "R2 gap between slots", gap, iv + 1);
      end
    end

    // R5: deferral while engine busy
    do_reset(4, 3);
    eng_busy = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (host_gnt) seen++;
      end
      chk(seen == 0, "R5 no grant while busy", seen, 0);
      chk(cell_ready == 1'b0, "R6 ready low while pending", cell_ready, 0);
      chk(eng_cell_valid == 1'b0, "R6 no cell while pending", eng_cell_valid, 0);
    end
    eng_busy = 1'b0;
    #1;
    chk(host_gnt == 1'b0, "R5 grant not same cycle", host_gnt, 0);
    @(negedge clk);
    chk(host_gnt == 1'b1, "R5 grant after busy falls", host_gnt, 1);

    // R4: early end by host_done
    do_reset(2, 15);
    measure(g0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    host_done = 1'b1;
    #1;
    chk(host_gnt == 1'b1, "R4 still in slot", host_gnt, 1);
    @(negedge clk);
    host_done = 1'b0;
    chk(host_gnt == 1'b0, "R4 done ends slot", host_gnt, 0);

    // R7/R8/R9/R11: host owns bus during slot
    do_reset(2, 15);
    measure(g0, 1'b0);
    eng_req = 1'b1; eng_we = 1'b1; eng_addr = 24'h3F_FFFC; eng_wdata = 32'h5555_5555;
    for (int b = 0; b < 4; b++) begin
      for (int hr = 0; hr < 2; hr++) begin
        logic [3:0] bexp;
        host_req   = hr[0];
        host_we    = 1'b1;
        host_addr  = {2'(b), 17'(b * 31 + 5), 3'b000, 2'b00};
        host_wdata = 32'hA5A5_0000 ^ 32'(b * 4099 + hr);
        #1;
        bexp = hr[0] ? (4'b0001 << b) : 4'b0000;
        chk(host_gnt == 1'b1 && eng_stall == 1'b1, "R7 slot active", eng_stall, 1);
        chk(mem_en == hr[0], "R7 mem_en follows host", mem_en, hr);
        chk(mem_we == hr[0], "R8 host writes static word", mem_we, hr);
        chk(mem_addr == host_addr, "R7 host address", mem_addr, host_addr);
        chk(mem_wdata == host_wdata, "R11 host data 32 bits", mem_wdata, host_wdata);
        chk(mem_bank == bexp, "R9 bank in slot", mem_bank, bexp);
        @(negedge clk);
      end
    end
    host_req = 1'b0;
    eng_req = 1'b0;

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule